// File: doc/BRIEF.md
# Deficit Idle Start Scheduler

This block is the start scheduler of a 64-bit, 8-lane transmit path. The word it controls holds eight byte lanes. In each clock cycle the scheduler makes one of three choices: fill the whole word with idle, start the waiting frame in lane 0, or start it in lane 4 behind four idle lanes. Start characters therefore appear only in lanes 0 and 4. The frame datapath reports the lane of the last byte of each frame. From that lane and the programmed inter-frame gap, the scheduler works out how many idle bytes it still owes.

The scheduler can keep a small deficit count. With the count enabled, it may shorten one gap by a few bytes and lengthen a later gap to pay them back. The average gap then stays at the programmed value, and no gap has to be rounded up to a full word. With the count disabled, the gap is rounded up instead, with a lane-4 start used wherever it fits. Frame data, encoding and scrambling belong to other blocks. The start decision and the idle decision are combinational outputs in the same cycle as the request. A frame end takes effect from the next cycle.

Top module: `dic_start_aligner`

## Requirements
- R1: After reset, the remaining-gap count and the deficit are both zero. With no frame pending, `idle_fill` is 1 and `start_go` is 0. The first pending frame starts in lane 0.
- R2: In a frame, `frame_end` with last-byte lane k (0..7) loads the remaining gap with max(G − (8 − k), 0). G is the effective gap.
- R3: Outside a frame, the cycle is idle-filled and no frame starts when the remaining gap plus the deficit exceeds 7. With the deficit count disabled, this also happens when the remaining gap exceeds 4.
- R4: Every idle-filled cycle takes 8 from the remaining gap. If the result is below zero, the remaining gap becomes 0. With the deficit count enabled, the deficit also becomes max(deficit + result, 0).
- R5: A start goes to lane 4 (`start_lane4` = 1) when the remaining gap exceeds a threshold, or whenever `force_lane4` is 1. Otherwise it goes to lane 0. The threshold is 3 − deficit with the deficit count enabled and 0 with it disabled.
- R6: At a start with the deficit count enabled, the deficit becomes the old deficit plus the remaining gap, less 4 for a lane-4 start. The result is clipped to the range 0..3. The remaining gap then becomes 0.
- R7: From the cycle after a start, through the cycle that carries `frame_end`, both `start_go` and `idle_fill` are 0. `frame_end` outside a frame is ignored.
- R8: A programmed gap below 8 acts as a gap of 8. Values from 8 to 63 are used as programmed.
- R9: When `cfg_dic_en` is 0, the deficit is treated as zero and cleared. It is zero when the count is enabled again.
- R10: A frame starts only in a cycle where `frame_pending` is 1. With no frame pending outside a frame, the cycle is idle-filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_gap | input | 6 | Programmed inter-frame gap in bytes |
| cfg_dic_en | input | 1 | Enables the deficit idle count |
| frame_pending | input | 1 | A frame is waiting to start |
| force_lane4 | input | 1 | Forces the next start into lane 4 |
| frame_end | input | 1 | The current word carries the last frame byte |
| frame_end_lane | input | 3 | Lane of the last frame byte (0..7) |
| start_go | output | 1 | Start the pending frame in this word |
| start_lane4 | output | 1 | The start goes to lane 4 (valid with start_go) |
| idle_fill | output | 1 | This word is all idle |

## Verification
`start_go`, `start_lane4` and `idle_fill` depend on the inputs of the current cycle and on state captured at the previous rising edge. A frame end or a deficit change given in cycle n therefore shows up only in the decisions of cycle n+1 and later. The bench drives every input at the falling edge and samples the outputs 1 ns before the next rising edge. It steps its reference state only after that sample, so its model and the registers advance on the same edge. The directed sequences chain frame ends and starts so that each expected lane depends on the gap and deficit carried over from earlier cycles.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   typedef enum logic [1:0] {
      ACT_BUSY  = 2'd0,
      ACT_IDLE  = 2'd1,
      ACT_START = 2'd2
   } dsa_act_e;

   function automatic int floor0(input int v);
      return (v < 0) ? 0 : v;
   endfunction

   function automatic int clip(input int v, input int hi);
      if (v < 0)  return 0;
      if (v > hi) return hi;
      return v;
   endfunction

endpackage

// File: rtl/dsa_decide.sv
module dsa_decide
   import dsa_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int GAP_W   = 6,
   parameter int DEF_W   = 2,
   parameter int DEF_MAX = 3,
   parameter int LANE_W  = 3
) (
   input  logic [GAP_W-1:0]  gap_eff,
   input  logic [GAP_W-1:0]  ifg_q,
   input  logic [DEF_W-1:0]  def_q,
   input  logic              dic_en,
   input  logic              in_frame_q,
   input  logic              pending,
   input  logic              force_l4,
   input  logic              end_ev,
   input  logic [LANE_W-1:0] end_lane,
   output dsa_act_e          act,
   output logic              lane4,
   output logic [GAP_W-1:0]  ifg_d,
   output logic [DEF_W-1:0]  def_d,
   output logic              in_frame_d
);

   localparam int HALF = LANES / 2;

   int   ifg_i, def_i, thr_i, rem_i, load_i;
   logic gap_hold;

   always_comb begin
      ifg_i    = int'(ifg_q);
      def_i    = dic_en ? int'(def_q) : 0;
      thr_i    = dic_en ? (DEF_MAX - def_i) : 0;
      gap_hold = (ifg_i + def_i > LANES - 1) || (!dic_en && ifg_i > HALF);
      load_i   = int'(gap_eff) - (LANES - int'(end_lane));

      act        = ACT_BUSY;
      lane4      = 1'b0;
      rem_i      = 0;
      ifg_d      = ifg_q;
      def_d      = def_q;
      in_frame_d = in_frame_q;

      if (in_frame_q) begin
         if (end_ev) begin
            ifg_d      = GAP_W'(floor0(load_i));
            in_frame_d = 1'b0;
         end
      end else if (gap_hold || !pending) begin
         act   = ACT_IDLE;
         rem_i = ifg_i - LANES;
         if (rem_i < 0) begin
            ifg_d = '0;
            def_d = DEF_W'(floor0(def_i + rem_i));
         end else begin
            ifg_d = GAP_W'(rem_i);
         end
      end else begin
         act        = ACT_START;
         lane4      = (ifg_i > thr_i) || force_l4;
         rem_i      = lane4 ? (ifg_i - HALF) : ifg_i;
         def_d      = DEF_W'(clip(def_i + rem_i, DEF_MAX));
         ifg_d      = '0;
         in_frame_d = 1'b1;
      end
   end

endmodule

// File: rtl/dsa_deficit.sv
module dsa_deficit #(
   parameter bit DIC_PRESENT = 1'b1,
   parameter int DEF_W       = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dic_en,
   input  logic [DEF_W-1:0] def_d,
   output logic [DEF_W-1:0] def_q
);

   generate
      if (DIC_PRESENT) begin : g_dic
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      def_q <= '0;
            else if (dic_en) def_q <= def_d;
            else             def_q <= '0;
         end
      end else begin : g_nodic
         assign def_q = '0;
      end
   endgenerate

endmodule

// File: rtl/dic_start_aligner.sv
module dic_start_aligner
   import dsa_pkg::*;
#(
   parameter int  LANES       = 8,
   parameter int  GAP_W       = 6,
   parameter int  GAP_MIN     = 8,
   parameter bit  DIC_PRESENT = 1'b1,
   localparam int LANE_W      = $clog2(LANES),
   localparam int DEF_MAX     = LANES / 2 - 1,
   localparam int DEF_W       = $clog2(DEF_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              cfg_dic_en,
   input  logic              frame_pending,
   input  logic              force_lane4,
   input  logic              frame_end,
   input  logic [LANE_W-1:0] frame_end_lane,
   output logic              start_go,
   output logic              start_lane4,
   output logic              idle_fill
);

   generate
      if (LANES < 4 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("LANES must be even and at least 4");
      end
      if (GAP_MIN >= (1 << GAP_W) || GAP_MIN < 1) begin : g_bad_gap
         $error("GAP_MIN must fit in GAP_W bits and be positive");
      end
      if (GAP_W < LANE_W + 1) begin : g_bad_gapw
         $error("GAP_W too narrow for one word of lanes");
      end
   endgenerate

   logic [GAP_W-1:0] gap_eff;
   logic [GAP_W-1:0] ifg_q, ifg_d;
   logic [DEF_W-1:0] def_q, def_d;
   logic             in_frame_q, in_frame_d;
   logic             dic_eff;
   logic             lane4;
   dsa_act_e         act;

   assign dic_eff = cfg_dic_en && DIC_PRESENT;
   assign gap_eff = (cfg_gap < GAP_W'(GAP_MIN)) ? GAP_W'(GAP_MIN) : cfg_gap;

   dsa_decide #(
      .LANES  (LANES),
      .GAP_W  (GAP_W),
      .DEF_W  (DEF_W),
      .DEF_MAX(DEF_MAX),
      .LANE_W (LANE_W)
   ) u_decide (
      .gap_eff   (gap_eff),
      .ifg_q     (ifg_q),
      .def_q     (def_q),
      .dic_en    (dic_eff),
      .in_frame_q(in_frame_q),
      .pending   (frame_pending),
      .force_l4  (force_lane4),
      .end_ev    (frame_end),
      .end_lane  (frame_end_lane),
      .act       (act),
      .lane4     (lane4),
      .ifg_d     (ifg_d),
      .def_d     (def_d),
      .in_frame_d(in_frame_d)
   );

   dsa_deficit #(
      .DIC_PRESENT(DIC_PRESENT),
      .DEF_W      (DEF_W)
   ) u_deficit (
      .clk   (clk),
      .rst_n (rst_n),
      .dic_en(dic_eff),
      .def_d (def_d),
      .def_q (def_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ifg_q      <= '0;
         in_frame_q <= 1'b0;
      end else begin
         ifg_q      <= ifg_d;
         in_frame_q <= in_frame_d;
      end
   end

   assign start_go    = (act == ACT_START);
   assign start_lane4 = start_go && lane4;
   assign idle_fill   = (act == ACT_IDLE);

endmodule

// File: rtl/dsa_check.sv
module dsa_check #(
   parameter int LANES   = 8,
   parameter int GAP_W   = 6,
   parameter int GAP_MIN = 8,
   parameter int DEF_W   = 2,
   parameter int LANE_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GAP_W-1:0]  cfg_gap,
   input logic              cfg_dic_en,
   input logic              frame_pending,
   input logic              force_lane4,
   input logic              frame_end,
   input logic [LANE_W-1:0] frame_end_lane,
   input logic              start_go,
   input logic              start_lane4,
   input logic              in_frame_q,
   input logic [GAP_W-1:0]  ifg_q,
   input logic [DEF_W-1:0]  def_q
);

   int gap_e, load_e;
   always_comb begin
      gap_e  = (int'(cfg_gap) < GAP_MIN) ? GAP_MIN : int'(cfg_gap);
      load_e = gap_e - LANES + int'(frame_end_lane);
      if (load_e < 0) load_e = 0;
   end

   p_end_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame_q && frame_end) |=> (int'(ifg_q) == $past(load_e)));

   p_gap_hold_dic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame_q && cfg_dic_en && (int'(ifg_q) + int'(def_q) > LANES - 1)) |-> !start_go);

   p_gap_hold_nodic_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame_q && !cfg_dic_en && (int'(ifg_q) > LANES / 2)) |-> !start_go);

   p_force_lane4_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_go && force_lane4) |-> start_lane4);

   p_lane0_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_go && !start_lane4 && cfg_dic_en) |=> (def_q >= $past(def_q)));

   p_single_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> !start_go);

   p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame_q |-> !start_go);

   p_dic_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dic_en |=> (def_q == '0));

   p_start_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |-> frame_pending);

endmodule

bind dic_start_aligner dsa_check #(
   .LANES  (LANES),
   .GAP_W  (GAP_W),
   .GAP_MIN(GAP_MIN),
   .DEF_W  (DEF_W),
   .LANE_W (LANE_W)
) u_dsa_check (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_gap       (cfg_gap),
   .cfg_dic_en    (cfg_dic_en),
   .frame_pending (frame_pending),
   .force_lane4   (force_lane4),
   .frame_end     (frame_end),
   .frame_end_lane(frame_end_lane),
   .start_go      (start_go),
   .start_lane4   (start_lane4),
   .in_frame_q    (in_frame_q),
   .ifg_q         (ifg_q),
   .def_q         (def_q)
);

// File: tb/dic_start_aligner_bench.sv
`timescale 1ns/1ps
module dic_start_aligner_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cfg_gap = 6'd12;
   logic       cfg_dic_en = 1'b1;
   logic       frame_pending = 1'b0;
   logic       force_lane4 = 1'b0;
   logic       frame_end = 1'b0;
   logic [2:0] frame_end_lane = 3'd0;
   logic       start_go, start_lane4, idle_fill;

   always #10 clk = ~clk;

   dic_start_aligner u_dic_start_aligner (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_gap       (cfg_gap),
      .cfg_dic_en    (cfg_dic_en),
      .frame_pending (frame_pending),
      .force_lane4   (force_lane4),
      .frame_end     (frame_end),
      .frame_end_lane(frame_end_lane),
      .start_go      (start_go),
      .start_lane4   (start_lane4),
      .idle_fill     (idle_fill)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   int m_ifg = 0;
   int m_def = 0;
   bit m_inf = 1'b0;
   bit o_s, o_l, o_i;

   function automatic int lo0(input int v);
      return (v < 0) ? 0 : v;
   endfunction

   task automatic model(input int gap, input bit dic, input bit pend, input bit frc,
                        input bit endv, input int lane,
                        output bit es, output bit el, output bit ei);
      int ge, d, t, thr;
      ge = (gap < 8) ? 8 : gap;
      d  = dic ? m_def : 0;
      es = 1'b0; el = 1'b0; ei = 1'b0;
      if (m_inf) begin
         if (endv) begin
            m_ifg = lo0(ge - (8 - lane));
            m_inf = 1'b0;
         end
      end else if ((m_ifg + d > 7) || (!dic && m_ifg > 4) || !pend) begin
         ei = 1'b1;
         t  = m_ifg - 8;
         if (t < 0) begin
            m_ifg = 0;
            m_def = lo0(d + t);
         end else begin
            m_ifg = t;
         end
      end else begin
         es  = 1'b1;
         thr = dic ? (3 - d) : 0;
         el  = (m_ifg > thr) || frc;
         t   = el ? (m_ifg - 4) : m_ifg;
         m_def = lo0(d + t);
         if (m_def > 3) m_def = 3;
         m_ifg = 0;
         m_inf = 1'b1;
      end
      if (!dic) m_def = 0;
   endtask

   task automatic check(input bit es, input bit el, input bit ei, input string tag);
      n_chk++;
      if ({o_s, o_l, o_i} !== {es, el, ei}) begin
         n_fail++;
         $display("FAIL %s: actual start=%0b lane4=%0b idle=%0b expected start=%0b lane4=%0b idle=%0b",
                  tag, o_s, o_l, o_i, es, el, ei);
      end
   endtask

   task automatic step(input int gap, input bit dic, input bit pend, input bit frc,
                       input bit endv, input int lane, input string tag);
      bit es, el, ei;
      @(negedge clk);
      cfg_gap        = 6'(gap);
      cfg_dic_en     = dic;
      frame_pending  = pend;
      force_lane4    = frc;
      frame_end      = endv;
      frame_end_lane = 3'(lane);
      #9;
      o_s = start_go; o_l = start_lane4; o_i = idle_fill;
      model(gap, dic, pend, frc, endv, lane, es, el, ei);
      check(es, el, ei, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250615));
      repeat (3) @(posedge clk);
      #5;
      o_s = start_go; o_l = start_lane4; o_i = idle_fill;
      check(1'b0, 1'b0, 1'b1, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset, then the first start lands in lane 0
      step(12, 1, 0, 0, 0, 0, "R1 idle no pending");   check(0, 0, 1, "R1 hand");
      step(12, 1, 1, 0, 0, 0, "R1 first start");       check(1, 0, 0, "R1 hand lane0");
      // R2, R3, R5, R6 with the deficit count on, gap 12
      step(12, 1, 0, 0, 1, 7, "R7 end in frame");      check(0, 0, 0, "R7 hand");
      step(12, 1, 1, 0, 0, 0, "R2 R3 gap hold");       check(0, 0, 1, "R3 hand");
      step(12, 1, 1, 0, 0, 0, "R5 lane0 start");       check(1, 0, 0, "R5 hand");
      step(12, 1, 0, 0, 1, 7, "R7 end");               check(0, 0, 0, "R7 hand");
      step(12, 1, 1, 0, 0, 0, "R3 gap hold");          check(0, 0, 1, "R3 hand");
      step(12, 1, 1, 0, 0, 0, "R6 deficit lane4");     check(1, 1, 0, "R6 hand");
      // R8: programmed gap 3 acts as 8; R9: deficit cleared while disabled
      step(3, 0, 0, 0, 1, 7, "R8 end small gap");      check(0, 0, 0, "R7 hand");
      step(3, 0, 1, 0, 0, 0, "R8 clamp idle");         check(0, 0, 1, "R8 hand");
      step(3, 0, 1, 0, 0, 0, "R8 start");              check(1, 0, 0, "R8 hand lane0");
      step(12, 1, 0, 0, 1, 7, "R9 end");               check(0, 0, 0, "R7 hand");
      step(12, 1, 1, 0, 0, 0, "R9 hold");              check(0, 0, 1, "R3 hand");
      step(12, 1, 1, 0, 0, 0, "R9 deficit was clear"); check(1, 0, 0, "R9 hand");
      // R3: force does not override the gap hold; R5: force
      step(12, 1, 0, 0, 1, 7, "R7 end");
      step(12, 1, 1, 1, 0, 0, "R3 force under hold"); check(0, 0, 1, "R3 hand force");
      step(12, 1, 1, 0, 0, 0, "R5 start");
      step(12, 0, 0, 0, 1, 3, "R2 end lane3");
      step(12, 0, 1, 0, 0, 0, "R4 underflow idle");   check(0, 0, 1, "R4 hand");
      step(12, 0, 1, 1, 0, 0, "R5 forced lane4");     check(1, 1, 0, "R5 hand force");
      // R10: no pending means idle
      step(12, 0, 0, 0, 1, 7, "R7 end");
      step(12, 0, 0, 0, 0, 0, "R10 idle");            check(0, 0, 1, "R10 hand");
      step(12, 0, 0, 0, 0, 0, "R10 idle");            check(0, 0, 1, "R10 hand");
      step(12, 0, 1, 0, 0, 0, "R10 start");           check(1, 0, 0, "R10 hand");
      // R4: idle underflow trims the deficit
      step(12, 1, 0, 0, 1, 7, "R2 end");
      step(12, 1, 1, 0, 0, 0, "R3 hold");
      step(12, 1, 1, 0, 0, 0, "R6 lane0 deficit 3");  check(1, 0, 0, "R6 hand");
      step(12, 1, 0, 0, 1, 2, "R2 end lane2");
      step(12, 1, 1, 0, 0, 0, "R4 idle underflow");   check(0, 0, 1, "R4 hand idle");
      step(12, 1, 1, 0, 0, 0, "R4 start");            check(1, 0, 0, "R4 hand lane0");
      step(12, 1, 0, 0, 1, 5, "R2 end lane5");
      step(12, 1, 1, 0, 0, 0, "R4 hold");             check(0, 0, 1, "R4 hand idle2");
      step(12, 1, 1, 0, 0, 0, "R4 trimmed deficit");  check(1, 0, 0, "R4 hand trimmed");
      // R7: end outside a frame is ignored
      step(12, 1, 0, 0, 1, 7, "R2 end");
      step(12, 1, 0, 0, 1, 0, "R7 stray end");        check(0, 0, 1, "R7 hand stray");
      step(12, 1, 1, 0, 0, 0, "R7 after stray");

      begin
         int cd = 0;
         int g  = 12;
         bit d  = 1'b1;
         for (int c = 0; c < 4000; c++) begin
            bit pend, frc, endv;
            int lane;
            if (c % 400 == 0) begin
               g = $urandom_range(0, 63);
               d = 1'($urandom_range(0, 1));
            end
            lane = $urandom_range(0, 7);
            frc  = ($urandom_range(0, 9) == 0);
            pend = ($urandom_range(0, 9) < 7);
            if (m_inf) begin
               endv = (cd == 0);
               if (cd > 0) cd--;
               step(g, d, pend, frc, endv, lane, "R7 R2 in frame");
            end else begin
               endv = ($urandom_range(0, 9) == 0);
               step(g, d, pend, frc, endv, lane, "R3 R5 R6 R10 schedule");
            end
            if (o_s) cd = $urandom_range(0, 5);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule